// File: doc/BRIEF.md
# Conversion Result Byte Register with Coherent Read

This block holds the latest 10-bit sample from an analog-to-digital converter and presents it to an 8-bit read bus as two bytes at adjacent addresses. A one-cycle completion strobe loads the sample. A justification input chooses how the 10 bits are placed inside the 16-bit byte pair: flush to the bottom, or flush to the top.

A reader that needs all ten bits fetches the lower address first and then the upper one. Between those two reads, the block keeps the visible sample fixed, so both bytes come from the same conversion. Samples that complete during that window go to a one-entry holding slot, and each newer one replaces the older. When the upper byte is read, the held sample becomes visible. A reader that only needs eight bits can read the upper byte of a top-justified value on its own, and the visible sample never freezes.

Top module: `adc_result_latch`

## Requirements
- R1: After reset, a read of either byte address returns 0x00.
- R2: With `left_align` low, the upper byte carries sample bits 9:8 in its bits 1:0 and zeros in bits 7:2. The lower byte carries sample bits 7:0.
- R3: With `left_align` high, the upper byte carries sample bits 9:2. The lower byte carries sample bits 1:0 in its bits 7:6 and zeros in bits 5:0.
- R4: A `conv_done` pulse loads `conv_value` so that it is visible from the next cycle, provided the block is not frozen and no lower-byte read happens in the same cycle.
- R5: A read at `BASE_ADDR` (lower byte) freezes the visible sample. While it is frozen, further `conv_done` pulses and further lower-byte reads do not change what either byte returns.
- R6: A read at `BASE_ADDR+1` (upper byte) while frozen returns the frozen sample and releases the freeze. From the next cycle the newest sample that arrived during the freeze is visible. A `conv_done` in the releasing cycle counts as the newest sample.
- R7: An upper-byte read while not frozen does not freeze, so later samples load as in R4.
- R8: Toggling `left_align` changes only how the sample is presented, not the stored sample. Reading the same stored value back under either setting gives the R2 and R3 layouts of one and the same value.
- R9: `rd_data` is 0x00 when `rd_en` is low or when `rd_addr` matches neither byte address. Such cycles do not freeze the block.
- R10: A `conv_done` pulse in the same cycle as a lower-byte read goes to the holding slot, not to the visible sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_value | input | RES_W | Finished sample |
| left_align | input | 1 | 1: top-justified, 0: bottom-justified |
| rd_en | input | 1 | Read access this cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | BYTE_W | Byte returned, combinational in the read cycle |

## Verification
A wrong freeze flag shows up at the port the first time a sample arrives between a lower-byte read and its matching upper-byte read. The upper byte, or the next lower byte, then belongs to the wrong conversion, and this is visible on the very next read. A stale or lost holding slot shows up as a wrong lower byte on the first read after the release. A justification fault corrupts the byte in the same cycle it is read, so the bench reads every sample under both settings and checks every such read in the cycle it happens.

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              left_align,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD    = PAIR_W - RES_W;
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  logic [RES_W-1:0]  shown_q, pend_q;
  logic              locked_q, pend_vld_q;
  logic              lo_rd, hi_rd, hold, unlock;
  logic [PAIR_W-1:0] pair;

  assign lo_rd  = rd_en && (rd_addr == LO_ADDR);
  assign hi_rd  = rd_en && (rd_addr == HI_ADDR);
  assign hold   = locked_q || lo_rd;
  assign unlock = hi_rd && locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q    <= '0;
      pend_q     <= '0;
      locked_q   <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (unlock) begin
      locked_q   <= 1'b0;
      pend_vld_q <= 1'b0;
      if (conv_done)       shown_q <= conv_value;
      else if (pend_vld_q) shown_q <= pend_q;
    end else begin
      if (lo_rd) locked_q <= 1'b1;
      if (conv_done) begin
        if (hold) begin
          pend_q     <= conv_value;
          pend_vld_q <= 1'b1;
        end else begin
          shown_q <= conv_value;
        end
      end
    end
  end

  assign pair    = left_align ? {shown_q, {PAD{1'b0}}} : {{PAD{1'b0}}, shown_q};
  assign rd_data = lo_rd ? pair[BYTE_W-1:0] :
                   hi_rd ? pair[PAIR_W-1:BYTE_W] : '0;
endmodule

module adc_result_latch_chk #(
  parameter int RES_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_value,
  input logic              left_align,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  shown_q,
  input logic [RES_W-1:0]  pend_q,
  input logic              locked_q,
  input logic              pend_vld_q
);
  localparam int PAD = 2 * BYTE_W - RES_W;
  localparam logic [BYTE_W-1:0] LO_MASK = BYTE_W'((1 << PAD) - 1);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  logic lo_rd, hi_rd;
  assign lo_rd = rd_en && (rd_addr == LO_ADDR);
  assign hi_rd = rd_en && (rd_addr == HI_ADDR);

  a_r2_right_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd && !left_align |-> (rd_data >> (RES_W - BYTE_W)) == '0);
  a_r3_left_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd && left_align |-> (rd_data & LO_MASK) == '0);
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !locked_q && !lo_rd |=> shown_q == $past(conv_value));
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && !hi_rd |=> $stable(shown_q) && locked_q);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd && locked_q |=> !locked_q && !pend_vld_q);
  a_r6_pending_shown: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd && locked_q && pend_vld_q && !conv_done |=> shown_q == $past(pend_q));
  a_r7_no_lock_on_upper: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd && !locked_q |=> !locked_q);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd && !hi_rd |-> rd_data == '0);
  a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd && conv_done && !locked_q |=> $stable(shown_q) && pend_vld_q);
endmodule

bind adc_result_latch adc_result_latch_chk #(
  .RES_W(RES_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
  .left_align(left_align), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .shown_q(shown_q), .pend_q(pend_q), .locked_q(locked_q), .pend_vld_q(pend_vld_q)
);

// File: tb/adc_result_latch_tb_top.sv
module adc_result_latch_tb_top;
  localparam logic [7:0] LO = 8'h40;
  localparam logic [7:0] HI = 8'h41;

  logic clk = 0, rst_n = 0;
  logic conv_done = 0, left_align = 0, rd_en = 0;
  logic [9:0] conv_value = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_result_latch dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
    .left_align(left_align), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {align, value, expected lower byte, expected upper byte}
  localparam logic [26:0] VEC [12] = '{
    {1'b0, 10'h3A5, 8'hA5, 8'h03}, {1'b1, 10'h3A5, 8'h40, 8'hE9},
    {1'b0, 10'h155, 8'h55, 8'h01}, {1'b1, 10'h155, 8'h40, 8'h55},
    {1'b0, 10'h0FF, 8'hFF, 8'h00}, {1'b1, 10'h0FF, 8'hC0, 8'h3F},
    {1'b0, 10'h200, 8'h00, 8'h02}, {1'b1, 10'h200, 8'h00, 8'h80},
    {1'b0, 10'h3FF, 8'hFF, 8'h03}, {1'b1, 10'h3FF, 8'hC0, 8'hFF},
    {1'b0, 10'h001, 8'h01, 8'h00}, {1'b1, 10'h001, 8'h40, 8'h00}
  };

  task automatic step(input logic en, input logic [7:0] a, input logic dn,
                      input logic [9:0] v, output logic [7:0] d);
    @(negedge clk);
    rd_en = en; rd_addr = a; conv_done = dn; conv_value = v;
    #2 d = rd_data;
    @(posedge clk);
    #1 rd_en = 0; conv_done = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cap(input logic [9:0] v);
    logic [7:0] d;
    step(0, LO, 1, v, d);
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
    logic [7:0] d;
    step(1, a, 0, '0, d);
    chk(tag, d, exp);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(LO, "R1 lower after reset", 8'h00);
    rd(HI, "R1 upper after reset", 8'h00);

    for (int i = 0; i < 12; i++) begin
      left_align = VEC[i][26];
      cap(VEC[i][25:16]);
      rd(LO, VEC[i][26] ? "R3 lower" : "R2 lower", VEC[i][15:8]);
      rd(HI, VEC[i][26] ? "R3 upper" : "R2 upper", VEC[i][7:0]);
    end
    left_align = 0;

    cap(10'h12C);
    rd(LO, "R4 lower", 8'h2C);
    cap(10'h0B7); cap(10'h2D3);
    rd(LO, "R5 lower frozen", 8'h2C);
    rd(HI, "R5 upper frozen", 8'h01);
    rd(LO, "R6 latest pending", 8'hD3);
    rd(HI, "R6 latest upper", 8'h02);

    cap(10'h12C);
    rd(LO, "R6 lower", 8'h2C);
    cap(10'h0B7);
    step(1, HI, 1, 10'h3E1, d);
    chk("R6 upper at release", d, 8'h01);
    rd(LO, "R6 release-cycle sample wins", 8'hE1);
    rd(HI, "R6 release-cycle upper", 8'h03);

    step(1, LO, 1, 10'h04A, d);
    chk("R10 lower same cycle", d, 8'hE1);
    rd(LO, "R10 still old", 8'hE1);
    rd(HI, "R10 upper old", 8'h03);
    rd(LO, "R10 held sample", 8'h4A);
    rd(HI, "R10 held upper", 8'h00);

    cap(10'h1F0);
    rd(HI, "R7 upper only", 8'h01);
    cap(10'h2AB);
    rd(HI, "R7 not frozen", 8'h02);
    rd(LO, "R7 lower", 8'hAB);
    rd(HI, "R7 release", 8'h02);

    cap(10'h3A5);
    rd(LO, "R8 lower right", 8'hA5);
    left_align = 1;
    rd(HI, "R8 upper left", 8'hE9);
    left_align = 0;
    rd(HI, "R8 upper right", 8'h03);
    left_align = 1;
    rd(LO, "R8 lower left", 8'h40);
    rd(HI, "R8 upper left again", 8'hE9);
    left_align = 0;

    step(0, LO, 0, '0, d);
    chk("R9 no enable", d, 8'h00);
    rd(8'h42, "R9 other address", 8'h00);
    rd(8'h3F, "R9 address below", 8'h00);
    cap(10'h0C3);
    rd(LO, "R9 no freeze from idle", 8'hC3);
    rd(HI, "R9 upper", 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule